// File: doc/BRIEF.md
# SPI Console Egress Flow Controller

This block runs on the device side of a SPI console link. When a message frame has been written into the egress read buffer, software or a producer issues a commit that carries the payload byte count. The block then raises a sideband ready line. This tells the external SPI host that a frame is waiting. It follows the host through the readout by watching the chip-select line, which it synchronizes into the local clock domain. A frame is read as two back-to-back transfers: a fixed 12-byte header, then the payload. Each transfer starts with chip-select falling and ends with it rising.

The ready line is dropped as soon as chip-select is first seen low. The host has already committed to both transfers by then. The block stays busy until chip-select has gone low, high, low and high again in strict order. It then pulses done, clears the buffer write pointer and accepts the next commit. The block also keeps the next write address, which advances by the frame size modulo the buffer size, and a running frame number. When flow control is switched off, a commit only updates the pointer and the counter, and the block completes at once without any chip-select handshake.

Top module: `spicon_egress_ctrl`

## Requirements
- R1: While reset is held (synchronous, active low), the ready line, busy and done are low, and the write address and the frame number are zero. The expected chip-select level starts as low.
- R2: When flow control is enabled, a commit presented while busy is low is accepted on that clock edge. In the following cycle the ready line and busy are both high.
- R3: The frame size is 12 plus the committed payload length. After an accepted commit, the write address becomes (previous address + frame size) modulo BUF_BYTES, visible in the cycle after acceptance.
- R4: Every accepted commit increments the frame number by exactly one, wrapping at 2^FRAME_W.
- R5: The chip-select input passes through a two-stage synchronizer. A level change driven before rising edge k is first acted on at rising edge k+2, the third edge that samples it.
- R6: The ready line falls on the edge that acts on the first observed low chip-select level of a frame. Busy stays high at that point.
- R7: The handshake matches chip-select levels in strict alternation: low, high, low, high. A level that stays the same after it has matched does not advance the handshake.
- R8: When the fourth level (the second high) is matched, busy falls, done is high for exactly one cycle and the write address is cleared to zero, all in the same cycle.
- R9: A commit presented while busy is high is ignored: the write address and the frame number stay unchanged.
- R10: With flow control disabled, an accepted commit updates the address and the frame number. Done pulses in the next cycle, and the ready line and busy stay low. Chip-select activity then has no effect, and the address is not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fc_en_i | input | 1 | Enables the ready-line / chip-select handshake |
| commit_valid_i | input | 1 | Frame commit request |
| commit_len_i | input | LEN_W | Payload length in bytes of the committed frame |
| csb_i | input | 1 | Chip-select from the SPI bus, asynchronous, active low |
| tx_ready_o | output | 1 | Sideband ready line to the host |
| busy_o | output | 1 | Handshake in progress; commits are refused |
| done_o | output | 1 | One-cycle completion pulse |
| wr_addr_o | output | ADDR_W | Next egress buffer write address |
| frame_num_o | output | FRAME_W | Count of accepted frames |

## Verification
A phase register stuck or skipped shows at the ports within one chip-select level change, three clocks later. Busy and done would arrive early or never, and the write address would not clear. A ready line released at the wrong phase shows on the next observed low level. A wrong modulo or frame increment shows in the cycle right after a commit. The bench sweeps every payload length in both modes, so each wrap position of the address and of the frame counter is reached.

// File: rtl/spicon_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the SPI console egress flow controller.
// Assumes a fixed-size frame header that precedes every payload.
package spicon_pkg;

    // Bytes of header read before every payload.
    localparam int unsigned HDR_BYTES = 12;

    // Handshake phase. Bit 0 is the chip-select level awaited in that phase.
    typedef enum logic [1:0] {
        PH_HDR_LOW  = 2'd0,
        PH_HDR_HIGH = 2'd1,
        PH_PAY_LOW  = 2'd2,
        PH_PAY_HIGH = 2'd3
    } hs_phase_e;

endpackage : spicon_pkg

// File: rtl/spicon_csb_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for the asynchronous chip-select input.
// Assumes that chip-select idles high; every stage resets to that level.
module spicon_csb_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic csb_i,
    output logic csb_sync_o
);
    logic [STAGES-1:0] stage_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            // Shift chip-select one stage further into the clock domain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[g] <= 1'b1;
                end else if (g == 0) begin
                    stage_q[g] <= csb_i;
                end else begin
                    stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign csb_sync_o = stage_q[STAGES-1];

    // R5
    sync_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && (stage_q[0] != $past(csb_i)) |-> 1'b0)
        else $error("first stage did not capture chip-select");
endmodule : spicon_csb_sync

// File: rtl/spicon_hs_track.sv
`timescale 1ns/1ps
// Chip-select handshake tracker. After start, it raises the ready line and
// matches synchronized chip-select levels in the order low, high, low, high.
// Assumes that start is only given while the tracker is idle.
module spicon_hs_track
    import spicon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic csb_lvl_i,
    output logic busy_o,
    output logic tx_ready_o,
    output logic last_o
);
    hs_phase_e phase_q;
    logic      busy_q;
    logic      ready_q;
    logic      match;

    // A level counts only while busy and only when it equals the awaited one.
    assign match  = busy_q && (csb_lvl_i == phase_q[0]);
    assign last_o = match && (phase_q == PH_PAY_HIGH);

    // Advance the phase on each matched level and manage busy and ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_HDR_LOW;
            busy_q  <= 1'b0;
            ready_q <= 1'b0;
        end else if (start_i) begin
            phase_q <= PH_HDR_LOW;
            busy_q  <= 1'b1;
            ready_q <= 1'b1;
        end else if (match) begin
            if (phase_q == PH_HDR_LOW) begin
                ready_q <= 1'b0;
            end
            if (phase_q == PH_PAY_HIGH) begin
                busy_q  <= 1'b0;
                phase_q <= PH_HDR_LOW;
            end else begin
                phase_q <= hs_phase_e'(phase_q + 2'd1);
            end
        end
    end

    assign busy_o     = busy_q;
    assign tx_ready_o = ready_q;

    // R6
    ready_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_q |-> busy_q)
        else $error("ready high while idle");

    // R6
    ready_only_first_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_HDR_LOW) |-> !ready_q)
        else $error("ready still high after first low level");

    // R8
    busy_ends_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> $past(csb_lvl_i))
        else $error("handshake ended on a low chip-select");

    // R2
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_q)
        else $error("start while busy");
endmodule : spicon_hs_track

// File: rtl/spicon_frame_book.sv
`timescale 1ns/1ps
// Write-address and frame-number bookkeeping for the egress buffer.
// The address advances by header plus payload, modulo the buffer size, and
// is cleared after a flow-controlled readout completes.
// Assumes that accept and clear never coincide.
module spicon_frame_book
    import spicon_pkg::*;
#(
    parameter int unsigned BUF_BYTES = 2048,
    parameter int unsigned LEN_W     = 11,
    parameter int unsigned FRAME_W   = 16,
    localparam int unsigned ADDR_W   = $clog2(BUF_BYTES),
    localparam int unsigned SUM_W    = ((ADDR_W > LEN_W) ? ADDR_W : LEN_W) + 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept_i,
    input  logic [LEN_W-1:0]   len_i,
    input  logic               clear_i,
    output logic [ADDR_W-1:0]  addr_o,
    output logic [FRAME_W-1:0] frame_o
);
    localparam logic [SUM_W-1:0] BUF_S = SUM_W'(BUF_BYTES);
    localparam logic [SUM_W-1:0] HDR_S = SUM_W'(HDR_BYTES);

    logic [ADDR_W-1:0]  addr_q;
    logic [FRAME_W-1:0] frame_q;
    logic [SUM_W-1:0]   sum_w;
    logic [SUM_W-1:0]   wrap_w;

    // Next address: old address plus frame size, folded into the buffer.
    always_comb begin
        sum_w  = SUM_W'(addr_q) + HDR_S + SUM_W'(len_i);
        wrap_w = sum_w % BUF_S;
    end

    // Update the address and the frame counter on accept or clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            frame_q <= '0;
        end else if (accept_i) begin
            addr_q  <= ADDR_W'(wrap_w);
            frame_q <= frame_q + FRAME_W'(1);
        end else if (clear_i) begin
            addr_q  <= '0;
        end
    end

    assign addr_o  = addr_q;
    assign frame_o = frame_q;

    // R4
    frame_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_i |=> frame_q == FRAME_W'($past(frame_q) + FRAME_W'(1)))
        else $error("frame number did not step by one");

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept_i && !clear_i |=> $stable(addr_q) && $stable(frame_q))
        else $error("bookkeeping changed without cause");

    // R3
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        SUM_W'(addr_q) < BUF_S)
        else $error("address outside buffer");

    // R8
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept_i && clear_i))
        else $error("accept and clear together");
endmodule : spicon_frame_book

// File: rtl/spicon_egress_ctrl.sv
`timescale 1ns/1ps
// SPI console egress flow controller (top).
// Accepts frame commits, signals the host through a ready line, follows the
// four chip-select levels of the header and payload readouts, and keeps the
// buffer write address and the frame number.
// Assumes that csb_i is asynchronous and idles high.
module spicon_egress_ctrl #(
    parameter int unsigned BUF_BYTES   = 2048,
    parameter int unsigned LEN_W       = 11,
    parameter int unsigned FRAME_W     = 16,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned ADDR_W     = $clog2(BUF_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fc_en_i,
    input  logic               commit_valid_i,
    input  logic [LEN_W-1:0]   commit_len_i,
    input  logic               csb_i,
    output logic               tx_ready_o,
    output logic               busy_o,
    output logic               done_o,
    output logic [ADDR_W-1:0]  wr_addr_o,
    output logic [FRAME_W-1:0] frame_num_o
);
    logic csb_sync;
    logic busy;
    logic last;
    logic accept;
    logic start;
    logic done_q;

    assign accept = commit_valid_i && !busy;
    assign start  = accept && fc_en_i;

    spicon_csb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .csb_i      (csb_i),
        .csb_sync_o (csb_sync)
    );

    spicon_hs_track u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .csb_lvl_i  (csb_sync),
        .busy_o     (busy),
        .tx_ready_o (tx_ready_o),
        .last_o     (last)
    );

    spicon_frame_book #(
        .BUF_BYTES (BUF_BYTES),
        .LEN_W     (LEN_W),
        .FRAME_W   (FRAME_W)
    ) u_book (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept),
        .len_i    (commit_len_i),
        .clear_i  (last),
        .addr_o   (wr_addr_o),
        .frame_o  (frame_num_o)
    );

    // Completion pulse: end of a handshake or an unflow-controlled commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= last || (accept && !fc_en_i);
        end
    end

    assign busy_o = busy;
    assign done_o = done_q;

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q)
        else $error("done longer than one cycle");

    // R10
    nofc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !fc_en_i |=> !busy && !tx_ready_o && done_q)
        else $error("unflow-controlled commit misbehaved");

    // R2
    fc_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy && tx_ready_o)
        else $error("handshake did not start");

    // R8
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> wr_addr_o == '0 && !busy && done_q)
        else $error("completion did not clear address");
endmodule : spicon_egress_ctrl

// File: tb/sim_spicon_egress_ctrl.sv
`timescale 1ns/1ps
module sim_spicon_egress_ctrl;
    localparam int BUF = 40;
    localparam int LW  = 5;
    localparam int FW  = 3;
    localparam int AW  = $clog2(BUF);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fc_en = 1'b1;
    logic          cv = 1'b0;
    logic [LW-1:0] clen = '0;
    logic          csb = 1'b1;
    logic          txr, busy, done;
    logic [AW-1:0] addr;
    logic [FW-1:0] frame;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #2.5 clk = ~clk;

    spicon_egress_ctrl #(.BUF_BYTES(BUF), .LEN_W(LW), .FRAME_W(FW)) u0 (
        .clk(clk), .rst_n(rst_n), .fc_en_i(fc_en), .commit_valid_i(cv),
        .commit_len_i(clen), .csb_i(csb), .tx_ready_o(txr), .busy_o(busy),
        .done_o(done), .wr_addr_o(addr), .frame_num_o(frame)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic commit(input int len);
        cv   = 1'b1;
        clen = LW'(len);
        step();
        cv   = 1'b0;
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        int exp_addr;
        int exp_frame;
        repeat (4) step();
        // R1 reset state
        chk("R1 ready", int'(txr), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 addr", int'(addr), 0);
        chk("R1 frame", int'(frame), 0);
        rst_n = 1'b1;
        step();
        exp_frame = 0;

        // Flow-controlled sweep over every payload length
        for (int len = 0; len < (1 << LW); len++) begin
            commit(len);
            exp_frame = (exp_frame + 1) % (1 << FW);
            chk("R2 ready", int'(txr), 1);
            chk("R2 busy", int'(busy), 1);
            chk("R3 addr", int'(addr), (12 + len) % BUF);
            chk("R4 frame", int'(frame), exp_frame);
            // R9 refused commit while busy
            commit((len + 7) % (1 << LW));
            chk("R9 frame", int'(frame), exp_frame);
            chk("R9 addr", int'(addr), (12 + len) % BUF);
            // R7 high level while awaiting low does nothing
            repeat (3) step();
            chk("R7 busy idle-high", int'(busy), 1);
            chk("R7 ready idle-high", int'(txr), 1);
            // R5 / R6 first low
            csb = 1'b0;
            step(); step();
            chk("R5 ready before sync", int'(txr), 1);
            step();
            chk("R6 ready dropped", int'(txr), 0);
            chk("R6 busy held", int'(busy), 1);
            repeat (5) step();
            chk("R7 held low", int'(busy), 1);
            csb = 1'b1;
            repeat (4) step();
            chk("R7 after first high", int'(busy), 1);
            chk("R7 no early done", int'(done), 0);
            csb = 1'b0;
            repeat (4) step();
            chk("R7 after second low", int'(busy), 1);
            csb = 1'b1;
            step(); step();
            chk("R5 busy before sync", int'(busy), 1);
            step();
            chk("R8 busy fell", int'(busy), 0);
            chk("R8 done", int'(done), 1);
            chk("R8 addr cleared", int'(addr), 0);
            step();
            chk("R8 done one cycle", int'(done), 0);
        end

        // Flow control disabled: address accumulates
        fc_en = 1'b0;
        exp_addr = 0;
        for (int len = 0; len < (1 << LW); len++) begin
            commit(len);
            exp_addr  = (exp_addr + 12 + len) % BUF;
            exp_frame = (exp_frame + 1) % (1 << FW);
            chk("R10 done", int'(done), 1);
            chk("R10 busy", int'(busy), 0);
            chk("R10 ready", int'(txr), 0);
            chk("R3 addr nofc", int'(addr), exp_addr);
            chk("R4 frame nofc", int'(frame), exp_frame);
            csb = 1'b0;
            repeat (4) step();
            csb = 1'b1;
            repeat (4) step();
            chk("R10 csb ignored addr", int'(addr), exp_addr);
            chk("R10 csb ignored busy", int'(busy), 0);
            chk("R10 csb ignored done", int'(done), 0);
        end
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end
endmodule : sim_spicon_egress_ctrl